// File: doc/BRIEF.md
# Flash sector erase sequencer

This block is the command and timing core of a small parallel NOR-style flash model. The host drives active-low chip-enable, write-enable and output-enable strobes, an address and a data byte. The block turns qualified write cycles into command sequences. It runs a byte program, or it collects several sector erase requests inside a timed acceptance window and then erases them together. While an operation runs, a read returns a status byte instead of array data. The array is a register-based byte memory split into equal sectors, and each sector can be locked by a protect input.

All strobes are sampled on the block clock. A write or a read counts once, on the first clock edge at which its strobe combination is seen. Internal times (program, acceptance window, erase) are parameters counted in clock cycles.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset the block is in read mode, every array byte is 0xFF, and a read returns the array byte at the address.
- R2: A write is taken only on the first clock at which ceN=0, weN=0 and oeN=1 all hold; a cycle with oeN=0 or ceN=1 writes nothing and does not advance a command sequence.
- R3: Byte program is the writes 0xAA at unlock address A (0x555 cut to ADDR_W bits, 0x55 by default), 0x55 at unlock address B (0x2AA cut, 0xAA by default), 0xA0 at A, then one address/data write; PROG_CYCLES clocks after that last write the byte becomes old AND new data.
- R4: Programming a byte that is not blank finishes normally: the result is old AND new, and status bit 5 (failure flag) reads 0.
- R5: Any write that does not fit the expected next step of a sequence returns the block to read mode with no array change.
- R6: Sector erase is A:0xAA, B:0x55, A:0x80, A:0xAA, B:0x55, then 0x30 at any address of the sector (sector = top address bits); this opens an acceptance window of WIN_CYCLES clocks during which status bit 3 reads 0.
- R7: During the window, each write of 0x30 adds the sector of its address to the pending set; other writes are ignored.
- R8: When the window ends, status bit 3 reads 1 and erase runs for ERASE_CYCLES clocks, after which every byte of each pending sector is 0xFF and other sectors are unchanged; every write during erase is ignored.
- R9: From the final write of a program or erase sequence until completion, a read returns bit 7 = complement of the expected final bit 7 (1 for erase), bit 6 = a toggle that starts at 0 after reset and flips on every status read, bit 3 as in R6/R8, other bits 0; after completion reads return array data.
- R10: With protectMask bit s set, a program into sector s is dropped at once (read mode, byte unchanged) and sector s is never added to the erase set.
- R11: rdData changes only at the clock where a read (ceN=0, oeN=0, weN=1) is first seen and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; top bits select the sector |
| wrData | input | 8 | Command or program data |
| protectMask | input | NSECT | Per-sector lock, 1 = protected |
| rdData | output | 8 | Array byte or status byte of the last read |

## Verification
A write acts on the clock where its strobe is first seen, and read data is registered on the clock where the read strobe is first seen, so the bench samples rdData on the falling edge right after that clock and a scoreboard pops each expected byte at exactly that point. Program completes PROG_CYCLES clocks after its data write, the window closes WIN_CYCLES clocks after the first 0x30, and erase ends ERASE_CYCLES clocks later. The bench places every status read and every extra erase command well inside the phase it targets, and every array read after a margin past the phase end, so no check sits on a boundary clock.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_SETUP, ST_UNL3, ST_UNL4,
    ST_PADDR, ST_PROG, ST_WIN, ST_ERASE
  } seqState_t;

  typedef struct packed {
    logic       progCommit;
    logic       eraseCommit;
    logic       showStatus;
    logic       readStart;
    logic [7:0] statusByte;
  } ctrlStrobe_t;

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int NSECT        = 4,
  parameter int WIN_CYCLES   = 40,
  parameter int ERASE_CYCLES = 60,
  parameter int PROG_CYCLES  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic [NSECT-1:0]  protectMask,
  output ctrlStrobe_t       strobe,
  output logic [NSECT-1:0]  pendMask,
  output logic [ADDR_W-1:0] progAddr,
  output logic [7:0]        progData
);
  localparam int SECT_W = $clog2(NSECT);
  localparam int MAXA   = (WIN_CYCLES > ERASE_CYCLES) ? WIN_CYCLES : ERASE_CYCLES;
  localparam int MAXC   = (MAXA > PROG_CYCLES) ? MAXA : PROG_CYCLES;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam logic [10:0] UNL_A_FULL = 11'h555;
  localparam logic [10:0] UNL_B_FULL = 11'h2AA;
  localparam logic [ADDR_W-1:0] UNL_A = UNL_A_FULL[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] UNL_B = UNL_B_FULL[ADDR_W-1:0];

  seqState_t state, nxt;
  logic [CNT_W-1:0] cnt, lim;
  logic writeQual, writeQualD, readQual, readQualD;
  logic writeStart, readStart, timed, timerDone, toggle, expBit7;
  logic [SECT_W-1:0] sect;
  logic [NSECT-1:0] sectBit;

  assign writeQual  = !ceN && !weN && oeN;
  assign readQual   = !ceN && !oeN && weN;
  assign writeStart = writeQual && !writeQualD;
  assign readStart  = readQual && !readQualD;
  assign sect       = addr[ADDR_W-1 -: SECT_W];
  assign sectBit    = (NSECT'(1) << sect) & ~protectMask;
  assign timed      = (state == ST_PROG) || (state == ST_WIN) || (state == ST_ERASE);

  always_comb begin
    case (state)
      ST_PROG:  lim = CNT_W'(PROG_CYCLES - 1);
      ST_WIN:   lim = CNT_W'(WIN_CYCLES - 1);
      ST_ERASE: lim = CNT_W'(ERASE_CYCLES - 1);
      default:  lim = '0;
    endcase
  end
  assign timerDone = timed && (cnt == lim);

  always_comb begin
    nxt = state;
    case (state)
      ST_READ:  if (writeStart && wrData == 8'hAA && addr == UNL_A) nxt = ST_UNL1;
      ST_UNL1:  if (writeStart) nxt = (wrData == 8'h55 && addr == UNL_B) ? ST_UNL2 : ST_READ;
      ST_UNL2:  if (writeStart) begin
                  if (wrData == 8'hA0 && addr == UNL_A)      nxt = ST_PADDR;
                  else if (wrData == 8'h80 && addr == UNL_A) nxt = ST_SETUP;
                  else                                       nxt = ST_READ;
                end
      ST_SETUP: if (writeStart) nxt = (wrData == 8'hAA && addr == UNL_A) ? ST_UNL3 : ST_READ;
      ST_UNL3:  if (writeStart) nxt = (wrData == 8'h55 && addr == UNL_B) ? ST_UNL4 : ST_READ;
      ST_UNL4:  if (writeStart) nxt = (wrData == 8'h30) ? ST_WIN : ST_READ;
      ST_PADDR: if (writeStart) nxt = protectMask[sect] ? ST_READ : ST_PROG;
      ST_PROG:  if (timerDone) nxt = ST_READ;
      ST_WIN:   if (timerDone) nxt = ST_ERASE;
      ST_ERASE: if (timerDone) nxt = ST_READ;
      default:  nxt = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_READ;
      cnt <= '0;
      writeQualD <= 1'b0;
      readQualD <= 1'b0;
      toggle <= 1'b0;
      pendMask <= '0;
      progAddr <= '0;
      progData <= 8'hFF;
    end else begin
      state <= nxt;
      writeQualD <= writeQual;
      readQualD <= readQual;
      cnt <= (nxt != state || !timed) ? '0 : cnt + 1'b1;
      if (readStart && timed) toggle <= ~toggle;
      if (state == ST_UNL4 && nxt == ST_WIN) pendMask <= sectBit;
      else if (state == ST_WIN && writeStart && wrData == 8'h30) pendMask <= pendMask | sectBit;
      else if (state == ST_ERASE && timerDone) pendMask <= '0;
      if (state == ST_PADDR && writeStart) begin
        progAddr <= addr;
        progData <= wrData;
      end
    end
  end

  assign expBit7 = (state == ST_PROG) ? progData[7] : 1'b1;
  assign strobe.progCommit  = (state == ST_PROG) && timerDone;
  assign strobe.eraseCommit = (state == ST_ERASE) && timerDone;
  assign strobe.showStatus  = timed;
  assign strobe.readStart   = readStart;
  assign strobe.statusByte  = {~expBit7, toggle, 1'b0, 1'b0, state == ST_ERASE, 3'b000};

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && !writeStart) |=> state == ST_READ);
  // R6
  window_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WIN) |=> (state == ST_WIN || state == ST_ERASE));
  // R8
  erase_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE && writeStart && !timerDone) |=> (state == ST_ERASE && $stable(pendMask)));
  // R10
  protect_prog_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PADDR && writeStart && protectMask[sect]) |=> state == ST_READ);
  // R3
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    timed |-> cnt <= lim);
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NSECT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  ctrlStrobe_t       strobe,
  input  logic [NSECT-1:0]  pendMask,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [7:0]        progData,
  output logic [7:0]        rdData
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int SECT_SIZE = DEPTH / NSECT;

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gByte
    localparam int SIDX = g / SECT_SIZE;
    always_ff @(posedge clk) begin
      if (!rstN)
        mem[g] <= 8'hFF;
      else if (strobe.eraseCommit && pendMask[SIDX])
        mem[g] <= 8'hFF;
      else if (strobe.progCommit && progAddr == ADDR_W'(g))
        mem[g] <= mem[g] & progData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      rdData <= 8'h00;
    else if (strobe.readStart)
      rdData <= strobe.showStatus ? strobe.statusByte : mem[addr];
  end

  // R11
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.readStart |=> $stable(rdData));
  // R4
  no_fail_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.showStatus |-> !strobe.statusByte[5]);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int NSECT        = 4,
  parameter int WIN_CYCLES   = 40,
  parameter int ERASE_CYCLES = 60,
  parameter int PROG_CYCLES  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic [NSECT-1:0]  protectMask,
  output logic [7:0]        rdData
);
  ctrlStrobe_t       strobe;
  logic [NSECT-1:0]  pendMask;
  logic [ADDR_W-1:0] progAddr;
  logic [7:0]        progData;

  flash_seq_ctrl #(
    .ADDR_W(ADDR_W), .NSECT(NSECT), .WIN_CYCLES(WIN_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .wrData(wrData), .protectMask(protectMask),
    .strobe(strobe), .pendMask(pendMask), .progAddr(progAddr), .progData(progData)
  );

  flash_array #(.ADDR_W(ADDR_W), .NSECT(NSECT)) uArray (
    .clk(clk), .rstN(rstN), .addr(addr), .strobe(strobe), .pendMask(pendMask),
    .progAddr(progAddr), .progData(progData), .rdData(rdData)
  );
endmodule

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_C = 20;
  localparam logic [7:0] UA = 8'h55;
  localparam logic [7:0] UB = 8'hAA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [7:0] addr = '0, wrData = '0;
  logic [3:0] protectMask = '0;
  logic [7:0] rdData;

  int checks = 0, fails = 0;
  logic tog = 1'b0;
  logic [7:0] expQ[$];
  string tagQ[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_erase_seq uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .wrData(wrData), .protectMask(protectMask), .rdData(rdData)
  );

  task automatic wrRaw(input logic [7:0] a, input logic [7:0] d, input logic ceV, input logic oeV);
    @(negedge clk);
    addr = a; wrData = d; ceN = ceV; oeN = oeV; weN = 1'b0;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1; weN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wrRaw(a, d, 1'b0, 1'b1);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [7:0] stat(input logic exp7, input logic q3);
    stat = {~exp7, tog, 2'b00, q3, 3'b000};
    tog = ~tog;
  endfunction

  task automatic progCmd(input logic [7:0] a, input logic [7:0] d);
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'hA0); wr(a, d);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard on the falling edge after a read is first seen
  initial begin
    logic rdPrev, rdNow;
    rdPrev = 1'b0;
    forever begin
      @(posedge clk);
      rdNow = !ceN && !oeN && weN;
      if (rdNow && !rdPrev) begin
        @(negedge clk);
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL unexpected read: actual %02h expected none", rdData);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (rdData !== e) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", t, rdData, e);
          end
        end
      end
      rdPrev = rdNow;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(8'h10, 8'hFF, "R1 reset array read");
    // R3 program, R9 status while busy
    progCmd(8'h05, 8'h3C);
    rd(8'h05, stat(1'b0, 1'b0), "R9 program status");
    repeat (PROG_C + 5) @(negedge clk);
    rd(8'h05, 8'h3C, "R3 programmed byte");
    // R4 non-blank program
    progCmd(8'h05, 8'hC3);
    rd(8'h05, stat(1'b1, 1'b0), "R4 non-blank status no fail bit");
    repeat (PROG_C + 5) @(negedge clk);
    rd(8'h05, 8'h00, "R4 non-blank result");
    progCmd(8'h45, 8'h11); repeat (PROG_C + 5) @(negedge clk);
    progCmd(8'h85, 8'h22); repeat (PROG_C + 5) @(negedge clk);
    progCmd(8'hC5, 8'h33); repeat (PROG_C + 5) @(negedge clk);
    rd(8'h85, 8'h22, "R3 sector2 byte");
    // R10 protected program dropped
    protectMask = 4'b1000;
    progCmd(8'hC6, 8'h44);
    rd(8'hC6, 8'hFF, "R10 protected program ignored");
    // R2 write qualification
    wrRaw(UA, 8'hAA, 1'b0, 1'b0); wr(UB, 8'h55); wr(UA, 8'hA0); wr(8'h46, 8'h00);
    rd(8'h46, 8'hFF, "R2 oeN low blocks write");
    wrRaw(UA, 8'hAA, 1'b1, 1'b1); wr(UB, 8'h55); wr(UA, 8'hA0); wr(8'h46, 8'h00);
    rd(8'h46, 8'hFF, "R2 ceN high blocks write");
    // R5 malformed sequence
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'h90);
    rd(8'h45, 8'h11, "R5 back in read mode");
    wr(8'h47, 8'h00);
    rd(8'h47, 8'hFF, "R5 no array change");
    // R6 erase sequence on sector1
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(UA, 8'h80);
    wr(UA, 8'hAA); wr(UB, 8'h55); wr(8'h40, 8'h30);
    rd(8'h00, stat(1'b1, 1'b0), "R6 window status bit3 low");
    // R7 add sector0, protected sector3 not added
    wr(8'h00, 8'h30);
    wr(8'hC0, 8'h30);
    rd(8'h00, stat(1'b1, 1'b0), "R9 toggle flips in window");
    repeat (40) @(negedge clk);
    rd(8'h00, stat(1'b1, 1'b1), "R8 erase status bit3 high");
    // R8 writes during erase ignored
    progCmd(8'h86, 8'h00);
    repeat (50) @(negedge clk);
    rd(8'h05, 8'hFF, "R7 added sector0 erased");
    rd(8'h45, 8'hFF, "R8 sector1 erased, R9 array data after completion");
    rd(8'h85, 8'h22, "R8 sector2 untouched");
    rd(8'hC5, 8'h33, "R10 protected sector kept");
    rd(8'h86, 8'hFF, "R8 program during erase ignored");
    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule